// File: doc/BRIEF.md
# PHY Configuration Register Bridge

This block lets a host reach a bank of byte-wide PHY configuration registers through only two 16-bit host registers. One is a command register and the other is a data register. Writing the command register launches one PHY access, either a read or a write. A busy flag in the command register stays high until the access ends. For a write, the host loads the data register first and then issues the command. For a read, the host issues the command, waits for busy to drop, and collects the byte from the data register.

The PHY side is modelled by a behavioural register bank with a fixed access latency. Two status flags set themselves after a delay. The calibration-complete flag follows an enable bit in the pad control register. The delay-line-locked flag follows an enable bit in the delay-line status register. Each flag can also be forced high from outside for test.

The host port is a plain register port. It takes a write strobe with an address and data, and it reads combinationally from the same address. It never applies back-pressure, so every strobe is accepted in the cycle it is presented. Software throttles itself by polling busy.

Top module: `phy_bridge`

## Requirements
- R1: After reset the command register, the data register and every PHY register read as zero.
- R2: The command register is at host offset 0x300 and reads {6'b0, busy(bit 9), write(bit 8), index[7:0]}. The data register is at offset 0x304, and its bits 15:8 always read zero. Every other offset reads zero.
- R3: A command with bit 8 set copies the low byte of the data register into the PHY register selected by bits 7:0.
- R4: A command with bit 8 clear loads the selected PHY register into the data register's low byte. The data is there when busy is seen low.
- R5: Busy rises in the cycle after the command write. It stays high for exactly ACC_LAT cycles, and the access completes on the edge where it falls.
- R6: While busy is high, writes to the command register and writes to the data register are both ignored. The in-flight access keeps its index, direction and data.
- R7: An index at or above NREG is out of range. A write to it changes no register, and a read from it returns zero.
- R8: PHY register 0x03 bit 4 is calibration-complete. It goes high CAL_DLY cycles after PHY register 0x02 bit 1 is set, and it drops once that bit is cleared.
- R9: PHY register 0x00 bit 4 is delay-line-locked. It goes high DLL_DLY cycles after PHY register 0x00 bit 3 is set, and it drops once register 0x00 is written with bit 3 clear.
- R10: A value written to bit 4 of register 0x00 or register 0x03 is never read back; that bit always shows the flag. The test inputs tst_cal_set and tst_dll_set force the matching flag high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 12 | Host register offset, used for both writes and reads |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Combinational read data for host_addr |
| tst_cal_set | input | 1 | Forces calibration-complete high |
| tst_dll_set | input | 1 | Forces delay-line-locked high |

## Verification
Host reads are combinational, so the bench takes register values half a cycle after it drives the address. Busy is checked at the falling edge after every rising edge of an access: it is high for ACC_LAT samples and low on the next sample. Read data is taken only once busy is seen low. The flag delays are counted from the edge where the enabling write completes. The first read issued right after that write completes ACC_LAT+2 edges later, which is still before either delay expires, so it must show zero; a read after a long wait must show one.

// File: rtl/phy_bridge_pkg.sv
package phy_bridge_pkg;
  localparam int HOST_AW = 12;
  localparam logic [HOST_AW-1:0] OFS_CMD  = 12'h300;
  localparam logic [HOST_AW-1:0] OFS_DATA = 12'h304;

  localparam int CMD_WR_BIT   = 8;
  localparam int CMD_BUSY_BIT = 9;

  localparam logic [7:0] IDX_DLL    = 8'h00;
  localparam logic [7:0] IDX_PADCTL = 8'h02;
  localparam logic [7:0] IDX_PADSTS = 8'h03;
  localparam int DLL_EN_BIT = 3;
  localparam int CAL_EN_BIT = 1;
  localparam int FLAG_BIT   = 4;

  typedef struct packed {
    logic       wr;
    logic [7:0] idx;
  } phy_cmd_t;
endpackage

// File: rtl/phy_lock_timer.sv
module phy_lock_timer #(
  parameter int DLY = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic force_set,
  output logic ready
);
  localparam int CW = $clog2(DLY + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DLY);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (!arm)         cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign ready = (arm && (cnt == LIMIT)) || force_set;
endmodule

// File: rtl/phy_reg_bank.sv
module phy_reg_bank
  import phy_bridge_pkg::*;
#(
  parameter int NREG = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] widx,
  input  logic [7:0] wdata,
  input  logic [7:0] ridx,
  output logic [7:0] rdata,
  input  logic       cal_ready,
  input  logic       dll_ready,
  output logic       cal_arm,
  output logic       dll_arm
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [8:0] LIMIT = 9'(NREG);

  logic [7:0] mem [NREG];
  logic       w_in, r_in;

  assign w_in = ({1'b0, widx} < LIMIT);
  assign r_in = ({1'b0, ridx} < LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we && w_in) begin
      mem[widx[IW-1:0]] <= wdata;
    end
  end

  always_comb begin
    rdata = r_in ? mem[ridx[IW-1:0]] : 8'h00;
    if (ridx == IDX_DLL)    rdata[FLAG_BIT] = dll_ready;
    if (ridx == IDX_PADSTS) rdata[FLAG_BIT] = cal_ready;
  end

  assign cal_arm = mem[IDX_PADCTL[IW-1:0]][CAL_EN_BIT];
  assign dll_arm = mem[IDX_DLL[IW-1:0]][DLL_EN_BIT];
endmodule

// File: rtl/phy_xact_ctrl.sv
module phy_xact_ctrl
  import phy_bridge_pkg::*;
#(
  parameter int LAT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic        data_we,
  input  logic [15:0] wdata,
  input  logic [7:0]  rd_byte,
  output logic        busy,
  output phy_cmd_t    cmd,
  output logic [7:0]  data_q,
  output logic        phy_we
);
  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt;
  logic          last;

  assign last   = busy && (cnt == '0);
  assign phy_we = last && cmd.wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      cmd    <= '0;
      data_q <= '0;
    end else if (busy) begin
      if (last) begin
        busy <= 1'b0;
        if (!cmd.wr) data_q <= rd_byte;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else begin
      if (cmd_we) begin
        cmd.wr  <= wdata[CMD_WR_BIT];
        cmd.idx <= wdata[7:0];
        busy    <= 1'b1;
        cnt     <= CW'(LAT - 1);
      end
      if (data_we) data_q <= wdata[7:0];
    end
  end
endmodule

// File: rtl/phy_bridge.sv
module phy_bridge
  import phy_bridge_pkg::*;
#(
  parameter int ACC_LAT = 4,
  parameter int NREG    = 64,
  parameter int CAL_DLY = 6,
  parameter int DLL_DLY = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [11:0] host_addr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  input  logic        tst_cal_set,
  input  logic        tst_dll_set
);
  phy_cmd_t   cmd;
  logic       busy, phy_we;
  logic [7:0] data_q, rd_byte;
  logic       cal_arm, dll_arm, cal_ready, dll_ready;
  logic       cmd_wr;
  logic [7:0] cmd_idx;

  assign cmd_wr  = cmd.wr;
  assign cmd_idx = cmd.idx;

  phy_xact_ctrl #(.LAT(ACC_LAT)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd_we (host_we && (host_addr == OFS_CMD)),
    .data_we(host_we && (host_addr == OFS_DATA)),
    .wdata  (host_wdata),
    .rd_byte(rd_byte),
    .busy   (busy),
    .cmd    (cmd),
    .data_q (data_q),
    .phy_we (phy_we)
  );

  phy_reg_bank #(.NREG(NREG)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (phy_we),
    .widx     (cmd_idx),
    .wdata    (data_q),
    .ridx     (cmd_idx),
    .rdata    (rd_byte),
    .cal_ready(cal_ready),
    .dll_ready(dll_ready),
    .cal_arm  (cal_arm),
    .dll_arm  (dll_arm)
  );

  phy_lock_timer #(.DLY(CAL_DLY)) u_cal (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (cal_arm),
    .force_set(tst_cal_set),
    .ready    (cal_ready)
  );

  phy_lock_timer #(.DLY(DLL_DLY)) u_dll (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (dll_arm),
    .force_set(tst_dll_set),
    .ready    (dll_ready)
  );

  always_comb begin
    case (host_addr)
      OFS_CMD:  host_rdata = {6'b0, busy, cmd_wr, cmd_idx};
      OFS_DATA: host_rdata = {8'b0, data_q};
      default:  host_rdata = 16'h0000;
    endcase
  end
endmodule

// File: rtl/phy_bridge_chk.sv
module phy_bridge_chk
  import phy_bridge_pkg::*;
#(
  parameter int LAT = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_we,
  input logic [11:0] host_addr,
  input logic [15:0] host_rdata,
  input logic        busy,
  input logic        cmd_wr,
  input logic [7:0]  cmd_idx,
  input logic        cal_arm,
  input logic        cal_ready,
  input logic        tst_cal_set,
  input logic        dll_arm,
  input logic        dll_ready,
  input logic        tst_dll_set
);
  localparam int BW = $clog2(LAT + 2);
  logic [BW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1'b1;
    else           bcnt <= '0;
  end

  assert_busy_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(host_we && (host_addr == OFS_CMD)));

  assert_busy_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == BW'(LAT)));

  assert_cmd_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_we && (host_addr == OFS_CMD)) |=> ($stable(cmd_idx) && $stable(cmd_wr)));

  assert_data_hi_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == OFS_DATA) |-> (host_rdata[15:8] == 8'h00));

  assert_cal_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_arm && !tst_cal_set) |-> !cal_ready);

  assert_cal_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cal_ready) && !tst_cal_set) |-> $past(cal_arm));

  assert_dll_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!dll_arm && !tst_dll_set) |-> !dll_ready);
endmodule

bind phy_bridge phy_bridge_chk #(.LAT(ACC_LAT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_we    (host_we),
  .host_addr  (host_addr),
  .host_rdata (host_rdata),
  .busy       (busy),
  .cmd_wr     (cmd_wr),
  .cmd_idx    (cmd_idx),
  .cal_arm    (cal_arm),
  .cal_ready  (cal_ready),
  .tst_cal_set(tst_cal_set),
  .dll_arm    (dll_arm),
  .dll_ready  (dll_ready),
  .tst_dll_set(tst_dll_set)
);

// File: tb/phy_bridge_bench.sv
module phy_bridge_bench;
  localparam int LAT  = 4;
  localparam int NREG = 64;
  localparam int CDLY = 6;
  localparam int DDLY = 8;
  localparam logic [11:0] A_CMD  = 12'h300;
  localparam logic [11:0] A_DATA = 12'h304;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [11:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        tst_cal_set = 1'b0;
  logic        tst_dll_set = 1'b0;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  phy_bridge #(.ACC_LAT(LAT), .NREG(NREG), .CAL_DLY(CDLY), .DLL_DLY(DDLY)) u_phy_bridge (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tst_cal_set(tst_cal_set), .tst_dll_set(tst_dll_set)
  );

  function automatic logic [7:0] pat(input int i, input bit inv);
    logic [7:0] p;
    p = 8'((i * 37 + 11) & 255);
    return inv ? ~p : p;
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic hw(input logic [11:0] a, input logic [15:0] d);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rdh(input logic [11:0] a, output logic [15:0] v);
    host_addr = a;
    #1 v = host_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    rdh(A_CMD, v);
    while (v[9]) begin
      @(negedge clk);
      rdh(A_CMD, v);
    end
  endtask

  task automatic phy_wr(input logic [7:0] idx, input logic [15:0] d);
    hw(A_DATA, d);
    hw(A_CMD, {8'h01, idx});
    wait_idle();
  endtask

  task automatic phy_rd(input logic [7:0] idx, output logic [15:0] v);
    hw(A_DATA, 16'h0000);
    hw(A_CMD, {8'h00, idx});
    wait_idle();
    rdh(A_DATA, v);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R2: reset state and unmapped offset
    rdh(A_CMD, v);   chk("R1 cmd reset", v, 16'h0000);
    rdh(A_DATA, v);  chk("R1 data reset", v, 16'h0000);
    rdh(12'h308, v); chk("R2 unmapped", v, 16'h0000);
    for (int i = 0; i < NREG; i++) begin
      phy_rd(8'(i), v); chk("R1 phy reg reset", v, 16'h0000);
    end

    // R2: upper data bits read zero
    hw(A_DATA, 16'hAB5A);
    rdh(A_DATA, v); chk("R2 data hi zero", v, 16'h005A);

    // R5: busy timing with exact per-cycle samples
    hw(A_DATA, 16'h003C);
    hw(A_CMD, 16'h0105);
    for (int c = 0; c < LAT; c++) begin
      rdh(A_CMD, v); chk("R5 busy high", v, 16'h0305);
      @(negedge clk);
    end
    rdh(A_CMD, v); chk("R5 busy low", v, 16'h0105);
    phy_rd(8'h05, v); chk("R3 reg5 value", v, 16'h003C);

    // R3 / R4: sweep of all in-range registers, two patterns
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 1; i < NREG; i++)
        if (i != 2) phy_wr(8'(i), {8'hC3, pat(i, pass[0])});
      for (int i = 1; i < NREG; i++) begin
        if (i != 2) begin
          phy_rd(8'(i), v);
          chk(i == 3 ? "R10 reg3 flag bit" : "R4 sweep readback", v,
              {8'h00, (i == 3) ? (pat(i, pass[0]) & 8'hEF) : pat(i, pass[0])});
        end
      end
    end

    // R6: writes during busy ignored
    hw(A_DATA, 16'h0077);
    hw(A_CMD, 16'h0109);
    hw(A_CMD, 16'h000A);
    hw(A_DATA, 16'h0011);
    rdh(A_CMD, v);  chk("R6 cmd held", v, 16'h0309);
    rdh(A_DATA, v); chk("R6 data held", v, 16'h0077);
    wait_idle();
    phy_rd(8'h09, v);  chk("R6 write landed", v, 16'h0077);
    phy_rd(8'h0A, v);  chk("R6 reg10 untouched", v, {8'h00, pat(10, 1'b1)});

    // R7: out of range
    phy_wr(8'h45, 16'h00FF);
    phy_rd(8'h45, v); chk("R7 oor read zero", v, 16'h0000);
    phy_rd(8'h05, v); chk("R7 no alias write", v, {8'h00, pat(5, 1'b1)});
    phy_wr(8'hFF, 16'h00EE);
    phy_rd(8'hFF, v); chk("R7 top index zero", v, 16'h0000);

    // R8: calibration flag
    phy_wr(8'h02, 16'h0002);
    phy_rd(8'h03, v); chk("R8 cal not yet", v, {8'h00, pat(3, 1'b1) & 8'hEF});
    repeat (CDLY + 4) @(negedge clk);
    phy_rd(8'h03, v); chk("R8 cal done", v, {8'h00, pat(3, 1'b1) | 8'h10});
    phy_wr(8'h02, 16'h0000);
    phy_rd(8'h03, v); chk("R8 cal cleared", v, {8'h00, pat(3, 1'b1) & 8'hEF});
    tst_cal_set = 1'b1;
    phy_rd(8'h03, v); chk("R10 cal forced", v, {8'h00, pat(3, 1'b1) | 8'h10});
    tst_cal_set = 1'b0;

    // R9: delay-line flag
    phy_wr(8'h00, 16'h0008);
    phy_rd(8'h00, v); chk("R9 dll not yet", v, 16'h0008);
    repeat (DDLY + 4) @(negedge clk);
    phy_rd(8'h00, v); chk("R9 dll locked", v, 16'h0018);
    phy_wr(8'h00, 16'h0000);
    phy_rd(8'h00, v); chk("R9 dll cleared", v, 16'h0000);
    phy_wr(8'h00, 16'h0010);
    phy_rd(8'h00, v); chk("R10 stored bit hidden", v, 16'h0000);
    tst_dll_set = 1'b1;
    phy_rd(8'h00, v); chk("R10 dll forced", v, 16'h0010);
    tst_dll_set = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule